// File: doc/BRIEF.md
# Three-Channel Low-Voltage Detector Controller

This block is the digital side of a three-channel supply monitor. Each channel drives power-up and threshold-select lines for an external comparator and resistor divider. It receives one comparator output bit back, which is low while the watched supply sits below the selected threshold. Software programs each channel through a small register port. It turns the channel on, picks a detection level, and arms the channel for its next comparison. The controller gives back a latched "voltage fell" flag and a level interrupt for each channel.

Comparator output is not trusted right after power-up. When a channel is enabled, a settling counter advances on a fixed-rate timebase tick that does not depend on the system clock. Results and interrupts stay masked until that counter expires. A detected fall stays latched even after the supply recovers. Only an explicit re-arm clears it: a write that raises the interrupt-enable bit from 0 to 1 while the channel is enabled. A fall seen by a channel that was never re-armed is not recorded.

The three channels accept different sets of level codes. A write that carries an illegal code still updates the other fields, and the old level is kept.

Top module: `vdet_monitor`

## Requirements
- R1: After reset, all enables, interrupt enables, level codes, latched results and settling counters are zero. `reg_rdata` reads 0 at every address, and `irq` and `comp_en` are 0.
- R2: Channel register layout: bit 0 is the enable, bit 1 is the interrupt enable, bits 6:2 hold the level code and bit 7 (read only) is the result. Addresses 0, 1 and 2 select channels 0, 1 and 2. `comp_en[i]` follows the channel's enable bit. While a channel is disabled, its 5-bit slice of `lvl_sel` (channel i at bits 5i+4:5i) is 0 and its comparator input is ignored. A disabling write clears the latched result.
- R3: Address 3 reads the per-channel ready bits in bits 2:0. A channel becomes ready once SETTLE_TICKS `tick` pulses have been counted after it was enabled. Until then, its result bit reads 0 and its interrupt stays low.
- R4: When an armed, enabled and ready channel sees a low synchronized comparator level, it latches result = 1. The result holds after the comparator returns high.
- R5: A write that sets enable = 1 and raises interrupt enable from 0 to 1 clears the latched result and arms the channel. A write that leaves interrupt enable at 1 clears nothing.
- R6: A fall on a channel that has not been re-armed since it was last enabled, or since its last detection, latches nothing and raises no interrupt.
- R7: `irq[i]` is high exactly when channel i has result = 1, interrupt enable = 1 and ready = 1. It drops on the re-arm write and when interrupt enable is cleared.
- R8: Legal level codes are 0 to 17 for channel 0, 0 to 4 for channel 1 and 0 to 2 for channel 2. A write with any other code keeps the previous code and still updates the enable bits.
- R9: The comparator input passes through two flip-flops. The result bit first reads 1 after the third rising clock edge following a high-to-low change of the comparator input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Fixed-rate timebase pulse, one clock wide |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0..2 channels, 3 ready status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| cmp_out | input | 3 | Comparator outputs, low = below threshold |
| comp_en | output | 3 | Comparator and divider power enable per channel |
| lvl_sel | output | 15 | Level code per channel, 5 bits each |
| irq | output | 3 | Level interrupt per channel |

## Verification
Falls are applied at several points: before the settling counter expires, after it expires on an armed channel, on a disabled channel, and on a channel whose interrupt enable was already set when it was enabled again. Only the armed, settled case may latch, and each of the others isolates a different gate. A recovery after a latch, an interrupt-enable clear and a re-arm write separate holding the result from clearing it. Illegal codes are written at the edge of each channel's range. A comparator step is sampled cycle by cycle to pin the synchronizer latency.

// File: rtl/vdet_pkg.sv
package vdet_pkg;
   localparam int NUM_CH = 3;
   localparam int LVL_W  = 5;
   localparam int REG_W  = 8;
   localparam int ADDR_W = $clog2(NUM_CH + 1);

   // number of legal level codes per channel
   function automatic int code_count(input int ch);
      case (ch)
         0:       return 18;
         1:       return 5;
         default: return 3;
      endcase
   endfunction
endpackage

// File: rtl/vdet_sync.sv
module vdet_sync #(
   parameter int        W       = 3,
   parameter int        STAGES  = 2,
   parameter logic      RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      if (STAGES < 2) $error("vdet_sync: STAGES must be at least 2");
      if (W < 1)      $error("vdet_sync: W must be positive");
   end

   logic [W-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= {W{RST_VAL}};
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= {W{RST_VAL}};
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/vdet_settle.sv
module vdet_settle #(
   parameter int TICKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   output logic ready
);
   localparam int CNT_W = $clog2(TICKS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS);

   initial begin
      if (TICKS < 1) $error("vdet_settle: TICKS must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (!en)                  cnt_q <= '0;
      else if (tick && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign ready = en && (cnt_q == LAST);

   AST_READY_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(tick)); // R3
   AST_READY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && en) |=> (ready || !en)); // R3
endmodule

// File: rtl/vdet_channel.sv
module vdet_channel
   import vdet_pkg::*;
#(
   parameter int CODES        = 18,
   parameter int SETTLE_TICKS = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr,
   input  logic [LVL_W+1:0] wdata,
   input  logic             below,
   output logic             en,
   output logic             ie,
   output logic [LVL_W-1:0] lvl,
   output logic [LVL_W-1:0] lvl_out,
   output logic             result,
   output logic             ready,
   output logic             irq
);
   localparam logic [LVL_W-1:0] MAX_CODE = LVL_W'(CODES - 1);

   initial begin
      if (CODES < 1 || CODES > (1 << LVL_W))
         $error("vdet_channel: CODES does not fit the level field");
   end

   logic             en_q, ie_q, armed_q, result_q;
   logic [LVL_W-1:0] lvl_q;
   logic             w_en, w_ie, code_ok, rearm, turn_off, detect;
   logic [LVL_W-1:0] w_lvl;

   assign w_en     = wdata[0];
   assign w_ie     = wdata[1];
   assign w_lvl    = wdata[LVL_W+1:2];
   assign code_ok  = (w_lvl <= MAX_CODE);
   assign rearm    = wr && w_en && w_ie && !ie_q;
   assign turn_off = wr && !w_en;
   assign detect   = en_q && ready && armed_q && below;

   vdet_settle #(.TICKS(SETTLE_TICKS)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_q),
      .tick  (tick),
      .ready (ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         ie_q  <= 1'b0;
         lvl_q <= '0;
      end else if (wr) begin
         en_q <= w_en;
         ie_q <= w_ie;
         if (code_ok) lvl_q <= w_lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         result_q <= 1'b0;
      end else if (turn_off) begin
         armed_q  <= 1'b0;
         result_q <= 1'b0;
      end else if (rearm) begin
         armed_q  <= 1'b1;
         result_q <= 1'b0;
      end else if (detect) begin
         armed_q  <= 1'b0;
         result_q <= 1'b1;
      end
   end

   assign en      = en_q;
   assign ie      = ie_q;
   assign lvl     = lvl_q;
   assign lvl_out = en_q ? lvl_q : '0;
   assign result  = result_q;
   assign irq     = result_q && ie_q && ready;

   AST_OFF_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !result_q); // R2
   AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (result_q && !turn_off && !rearm) |=> result_q); // R4
   AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> !result_q); // R5
   AST_LATCH_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(result_q) |-> $past(armed_q)); // R6
   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= MAX_CODE); // R8
   AST_BAD_CODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !code_ok) |=> $stable(lvl_q)); // R8
endmodule

// File: rtl/vdet_monitor.sv
module vdet_monitor
   import vdet_pkg::*;
#(
   parameter int SETTLE_TICKS = 1000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick,
   input  logic                      reg_wr,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [REG_W-1:0]          reg_wdata,
   output logic [REG_W-1:0]          reg_rdata,
   input  logic [NUM_CH-1:0]         cmp_out,
   output logic [NUM_CH-1:0]         comp_en,
   output logic [NUM_CH*LVL_W-1:0]   lvl_sel,
   output logic [NUM_CH-1:0]         irq
);
   localparam int FIELD_W = LVL_W + 2;

   initial begin
      if (FIELD_W + 1 > REG_W) $error("vdet_monitor: register too narrow");
      if (NUM_CH > REG_W)      $error("vdet_monitor: too many channels");
   end

   logic [NUM_CH-1:0] cmp_s, below, ready;
   logic [REG_W-1:0]  ch_rd [NUM_CH];
   logic              unused_wbits;

   assign unused_wbits = ^reg_wdata[REG_W-1:FIELD_W];

   vdet_sync #(.W(NUM_CH), .STAGES(2), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_out),
      .q     (cmp_s)
   );
   assign below = ~cmp_s;

   genvar i;
   generate
      for (i = 0; i < NUM_CH; i++) begin : g_ch
         logic             en_i, ie_i, res_i, wr_i;
         logic [LVL_W-1:0] lvl_i;

         assign wr_i = reg_wr && (reg_addr == ADDR_W'(i));

         vdet_channel #(
            .CODES        (code_count(i)),
            .SETTLE_TICKS (SETTLE_TICKS)
         ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .wr      (wr_i),
            .wdata   (reg_wdata[FIELD_W-1:0]),
            .below   (below[i]),
            .en      (en_i),
            .ie      (ie_i),
            .lvl     (lvl_i),
            .lvl_out (lvl_sel[i*LVL_W +: LVL_W]),
            .result  (res_i),
            .ready   (ready[i]),
            .irq     (irq[i])
         );

         assign comp_en[i] = en_i;
         assign ch_rd[i]   = REG_W'({res_i && ready[i], lvl_i, ie_i, en_i});

         AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (ready[i] && comp_en[i])); // R7
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(NUM_CH)) reg_rdata[NUM_CH-1:0] = ready;
      for (int k = 0; k < NUM_CH; k++)
         if (reg_addr == ADDR_W'(k)) reg_rdata = ch_rd[k];
   end
endmodule

// File: tb/sim_vdet_monitor.sv
`timescale 1ns/1ps
module sim_vdet_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [2:0]  cmp_out = 3'b111;
   logic [2:0]  comp_en;
   logic [14:0] lvl_sel;
   logic [2:0]  irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   typedef struct { int kind; int exp; string tag; } item_t;
   item_t q[$];

   always #10 clk = ~clk;

   vdet_monitor #(.SETTLE_TICKS(4)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cmp_out(cmp_out), .comp_en(comp_en), .lvl_sel(lvl_sel), .irq(irq)
   );

   // monitor: pops expected items and compares with outputs
   initial forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
         item_t it;
         int act;
         it = q.pop_front();
         case (it.kind)
            0: act = int'(reg_rdata);
            1: act = int'(irq);
            2: act = int'(comp_en);
            default: act = int'(lvl_sel);
         endcase
         checks++;
         if (act != it.exp) begin
            fails++;
            $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.tag, it.kind, act, it.exp);
         end
      end
   end

   task automatic chk(input int kind, input int addr, input int exp, input string tag);
      @(negedge clk);
      reg_addr = 2'(addr);
      q.push_back('{kind, exp, tag});
      #4;
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'(addr); reg_wdata = 8'(data);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int t = 0; t < n; t++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic setcmp(input int ch, input logic v);
      @(negedge clk);
      cmp_out[ch] = v;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 4; a++) chk(0, a, 0, "R1 rdata");
      chk(1, 0, 0, "R1 irq");
      chk(2, 0, 0, "R1 comp_en");

      // enable ch0, level 5, no interrupt enable
      wr(0, 21);
      chk(0, 0, 21, "R2 layout");
      chk(2, 0, 1, "R2 comp_en");
      chk(3, 0, 5, "R2 lvl_sel");
      wr(0, 23);                   // re-arm before settling
      setcmp(0, 1'b0);
      idle(5);
      chk(0, 0, 23, "R3 result masked before ready");
      chk(1, 0, 0, "R3 irq masked before ready");
      chk(0, 3, 0, "R3 not ready");
      ticks(3);
      chk(0, 3, 0, "R3 not ready after 3 ticks");
      ticks(1);
      chk(0, 3, 1, "R3 ready after 4 ticks");
      chk(0, 0, 151, "R4 latched");
      chk(1, 0, 1, "R7 irq");
      setcmp(0, 1'b1);
      idle(5);
      chk(0, 0, 151, "R4 held after recovery");
      wr(0, 21);
      chk(0, 0, 149, "R7 result kept, ie off");
      chk(1, 0, 0, "R7 irq off with ie 0");
      wr(0, 23);
      chk(0, 0, 23, "R5 re-arm clears");
      chk(1, 0, 0, "R7 irq drops on re-arm");
      setcmp(0, 1'b0);
      idle(4);
      chk(0, 0, 151, "R4 latched again");
      chk(1, 0, 1, "R7 irq again");
      wr(0, 23);
      chk(0, 0, 151, "R5 ie 1 to 1 no clear");

      // disable, then re-enable with ie already 1
      wr(0, 22);
      chk(0, 0, 22, "R2 disable clears result");
      chk(2, 0, 0, "R2 comp_en off");
      chk(3, 0, 0, "R2 lvl_sel inactive");
      idle(5);
      chk(0, 0, 22, "R2 comparator ignored");
      wr(0, 23);
      ticks(4);
      idle(5);
      chk(0, 0, 23, "R6 no latch without re-arm");
      chk(1, 0, 0, "R6 no irq without re-arm");
      wr(0, 21);
      wr(0, 23);
      chk(0, 0, 151, "R5 re-arm then latch");
      chk(1, 0, 1, "R7 irq after re-arm");

      // level code sets
      wr(1, 16);
      chk(0, 1, 16, "R8 ch1 code 4");
      wr(1, 20);
      chk(0, 1, 16, "R8 ch1 code 5 rejected");
      wr(2, 8);
      chk(0, 2, 8, "R8 ch2 code 2");
      wr(2, 12);
      chk(0, 2, 8, "R8 ch2 code 3 rejected");
      wr(2, 124);
      chk(0, 2, 8, "R8 ch2 code 31 rejected");
      wr(0, 75);
      chk(0, 0, 151, "R8 ch0 code 18 rejected");
      wr(0, 71);
      chk(0, 0, 199, "R8 ch0 code 17");
      chk(3, 0, 17, "R8 lvl_sel ch0 17");
      wr(1, 17);
      chk(3, 0, 145, "R2 lvl_sel two channels");
      chk(2, 0, 3, "R2 comp_en two channels");

      // ch1 independent detection
      wr(1, 19);
      ticks(4);
      chk(0, 1, 19, "R6 ch1 clean");
      chk(1, 0, 1, "R7 only ch0 irq");
      setcmp(1, 1'b0);
      idle(4);
      chk(0, 1, 147, "R4 ch1 latched");
      chk(1, 0, 3, "R7 ch0 and ch1 irq");

      // ch2 synchronizer latency
      wr(2, 5);
      wr(2, 7);
      ticks(4);
      chk(0, 3, 7, "R3 all ready");
      setcmp(2, 1'b0);
      chk(0, 2, 7, "R9 one edge");
      chk(0, 2, 7, "R9 two edges");
      chk(0, 2, 135, "R9 three edges");
      chk(1, 0, 7, "R7 all irq");

      idle(3);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule